// File: doc/BRIEF.md
# Dual-Mode Auxiliary PWM Pair

This block drives two auxiliary pulse-width outputs. Each output has an 8-bit period value and an 8-bit on-time value. All counting runs on a step enable that fires on every second clock, so one count lasts two clocks. Typical loads are switching power stages or an RC filter that turns the pulse train into a slow analog level.

A mode input selects how the two channels relate. With the mode input high, the channels are independent: each has its own period and its own on-time. With the mode input low, both outputs share the channel-0 period, and the channel-1 period value sets how far the rising edge of output 1 trails the rising edge of output 0.

Software reaches the four values through a single write port made of an address, data and a write strobe. A new on-time is held back until the next PWM cycle begins. A period write in independent mode restarts that channel at once.

Top module: `aux_pwm_pair`

## Requirements
- R1: Write address map, 8 bits each, all values 0x00..0xFF accepted: address 0 = channel-0 period, 1 = channel-1 period, 2 = channel-0 on-time, 3 = channel-1 on-time; a write changes only the addressed value.
- R2: With period value P and on-time value N where N <= P, an output repeats every 2*(P+1) clocks and stays high for 2*N clocks of each cycle.
- R3: An on-time greater than the period keeps the output high for the whole cycle, including N = P+1; an on-time of 0 keeps it low.
- R4: With the mode input at 1, output 1 uses the channel-1 period and on-time, with no dependence on channel 0.
- R5: With the mode input at 0 and channel-1 period value Q below channel-0 period value P, both outputs repeat every 2*(P+1) clocks and output 1 rises 2*(Q+1) clocks after output 0 rises.
- R6: An on-time write changes the pulse only from the next cycle start. A cycle that is already running keeps the old high time.
- R7: With the mode input at 1, a period write resets that channel's counter to 0 on the write edge. If the on-time is nonzero, the output is high within two clocks.
- R8: With the mode input at 0, a period write does not restart any counter.
- R9: After reset both periods are 0xFF and both on-times are 0x00. Both outputs are low, and in shared-period mode the two outputs rise together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_addr | input | 2 | Register select (see R1) |
| wr_data | input | 8 | Value to write |
| indep_mode | input | 1 | 1 = independent channels, 0 = shared period with phase offset |
| pwm0 | output | 1 | Registered output of channel 0 |
| pwm1 | output | 1 | Registered output of channel 1 |

## Verification
The on-time write and the cycle-start reload can land on the same clock edge. In that case the reload must take one whole value, never a blend of old and new. The bench provokes this by sweeping the write across every clock of a 20-clock cycle, counted from a rising edge of the output. For each offset, the next pulse must be exactly twice the old or twice the new on-time, and the pulse after it must match the new value. A period write landing on a wrap edge is the second such coincidence. There the restart must win, and the bench observes this through the restart-latency check.

// File: rtl/auxpwm_pkg.sv
package auxpwm_pkg;
  localparam int PWM_W = 8;
  localparam int ADR_W = 2;

  typedef logic [PWM_W-1:0] cval_t;

  typedef enum logic [ADR_W-1:0] {
    A_PER0 = 2'd0,
    A_PER1 = 2'd1,
    A_ON0  = 2'd2,
    A_ON1  = 2'd3
  } reg_addr_e;

  localparam cval_t PER_RST = '1;
  localparam cval_t ON_RST  = '0;

  // counter has reached (or passed) the end of its cycle
  function automatic logic at_wrap(cval_t c, cval_t p);
    return c >= p;
  endfunction

  // output level for a count position under a given on-time
  function automatic logic duty_high(cval_t c, cval_t on);
    return c < on;
  endfunction

  // channel-0 position at which the delayed channel restarts
  function automatic logic phase_hit(cval_t c0, cval_t off);
    return c0 == off;
  endfunction
endpackage

// File: rtl/auxpwm_tick.sv
module auxpwm_tick (
  input  logic clk,
  input  logic rst,
  output logic step
);
  logic step_q;

  always_ff @(posedge clk) begin
    if (rst) step_q <= 1'b0;
    else     step_q <= ~step_q;
  end

  assign step = step_q;
endmodule

// File: rtl/auxpwm_regs.sv
module auxpwm_regs
  import auxpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  cval_t            wr_data,
  output cval_t            per0,
  output cval_t            per1,
  output cval_t            on0,
  output cval_t            on1,
  output logic             per0_wr,
  output logic             per1_wr
);
  reg_addr_e sel;
  logic      on0_wr, on1_wr;

  assign sel     = reg_addr_e'(wr_addr);
  assign per0_wr = wr_en && (sel == A_PER0);
  assign per1_wr = wr_en && (sel == A_PER1);
  assign on0_wr  = wr_en && (sel == A_ON0);
  assign on1_wr  = wr_en && (sel == A_ON1);

  always_ff @(posedge clk) begin
    if (rst) begin
      per0 <= PER_RST;
      per1 <= PER_RST;
      on0  <= ON_RST;
      on1  <= ON_RST;
    end else begin
      if (per0_wr) per0 <= wr_data;
      if (per1_wr) per1 <= wr_data;
      if (on0_wr)  on0  <= wr_data;
      if (on1_wr)  on1  <= wr_data;
    end
  end

  // R9
  reset_val_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (per0 == PER_RST && per1 == PER_RST && on0 == ON_RST && on1 == ON_RST));

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    per0_wr |=> ($stable(per1) && $stable(on0) && $stable(on1)));
endmodule

// File: rtl/auxpwm_chan.sv
module auxpwm_chan
  import auxpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  input  logic  restart,
  input  logic  sync,
  input  cval_t per,
  input  cval_t on_next,
  output logic  pwm,
  output cval_t cnt,
  output logic  cyc_start
);
  cval_t cnt_q;
  cval_t live_q;
  logic  pwm_q;
  logic  wrap;

  assign wrap      = at_wrap(cnt_q, per);
  assign cyc_start = restart || (step && (wrap || sync));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      live_q <= ON_RST;
      pwm_q  <= 1'b0;
    end else begin
      if (cyc_start) begin
        cnt_q  <= '0;
        live_q <= on_next;
      end else if (step) begin
        cnt_q  <= cnt_q + cval_t'(1);
      end
      pwm_q <= duty_high(cnt_q, live_q);
    end
  end

  assign pwm = pwm_q;
  assign cnt = cnt_q;

  // R2
  hold_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(cnt_q));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

  // R6
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> $stable(live_q));
endmodule

// File: rtl/aux_pwm_pair.sv
module aux_pwm_pair
  import auxpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [PWM_W-1:0] wr_data,
  input  logic             indep_mode,
  output logic             pwm0,
  output logic             pwm1
);
  logic  step;
  cval_t per0, per1, on0, on1;
  logic  per0_wr, per1_wr;
  logic  restart0, restart1;
  logic  sync1;
  cval_t per_ch1;
  cval_t cnt0, cnt1;
  logic  start0, start1;

  auxpwm_tick u_tick (
    .clk  (clk),
    .rst  (rst),
    .step (step)
  );

  auxpwm_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .per0    (per0),
    .per1    (per1),
    .on0     (on0),
    .on1     (on1),
    .per0_wr (per0_wr),
    .per1_wr (per1_wr)
  );

  // restarts only when the channels run on their own
  assign restart0 = per0_wr && indep_mode;
  assign restart1 = per1_wr && indep_mode;
  // in shared mode channel 1 borrows the channel-0 period and is re-phased
  assign per_ch1  = indep_mode ? per1 : per0;
  assign sync1    = !indep_mode && phase_hit(cnt0, per1);

  auxpwm_chan u_ch0 (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .restart   (restart0),
    .sync      (1'b0),
    .per       (per0),
    .on_next   (on0),
    .pwm       (pwm0),
    .cnt       (cnt0),
    .cyc_start (start0)
  );

  auxpwm_chan u_ch1 (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .restart   (restart1),
    .sync      (sync1),
    .per       (per_ch1),
    .on_next   (on1),
    .pwm       (pwm1),
    .cnt       (cnt1),
    .cyc_start (start1)
  );

  // R5
  phase_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && step && cnt0 == per1) |=> (cnt1 == '0));

  // R8
  no_restart_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && per0_wr && !start0) |=>
      (cnt0 == $past(cnt0) + cval_t'($past(step))));

  // R5
  shared_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && start0) |-> start1 || (per1 < per0));
endmodule

// File: tb/aux_pwm_pair_tb.sv
module aux_pwm_pair_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       indep_mode = 1'b0;
  logic       pwm0, pwm1;

  int total = 0;
  int bad = 0;

  localparam int K_PER = 0, K_HIGH = 1, K_CONST = 2, K_OFFS = 3, K_RISEWIN = 4;
  localparam int LIMIT = 3000;

  typedef struct {
    int    kind;
    int    ch;
    int    exp;
    int    alt;
    int    win;
    string tag;
  } item_t;

  item_t q[$];
  bit    mon_busy = 1'b0;

  always #2 clk = ~clk;

  aux_pwm_pair u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .indep_mode (indep_mode),
    .pwm0       (pwm0),
    .pwm1       (pwm1)
  );

  function automatic logic outv(int ch);
    return (ch == 0) ? pwm0 : pwm1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // writes use address map of R1: 0 per0, 1 per1, 2 on0, 3 on1
  task automatic wr(int a, int d);
    wr_en   = 1'b1;
    wr_addr = 2'(a);
    wr_data = 8'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(int kind, int ch, int exp, int alt, int win, string tag);
    item_t it;
    it.kind = kind; it.ch = ch; it.exp = exp; it.alt = alt; it.win = win; it.tag = tag;
    q.push_back(it);
    do @(negedge clk); while (q.size() != 0 || mon_busy);
  endtask

  task automatic wait_rise(int ch, output bit ok);
    logic prev = outv(ch);
    ok = 1'b0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (outv(ch) && !prev) begin ok = 1'b1; break; end
      prev = outv(ch);
    end
  endtask

  task automatic wait_fall(int ch, output bit ok);
    logic prev = outv(ch);
    ok = 1'b0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (!outv(ch) && prev) begin ok = 1'b1; break; end
      prev = outv(ch);
    end
  endtask

  task automatic run_item(item_t it);
    bit ok;
    int n;
    logic p0, p1, r1;
    case (it.kind)
      K_HIGH: begin
        wait_rise(it.ch, ok);
        n = 0;
        if (ok) begin
          n = 1;
          for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (!outv(it.ch)) break;
            n++;
          end
        end
        check(ok && (n == it.exp || n == it.alt), it.tag, n, it.exp);
      end
      K_PER: begin
        wait_rise(it.ch, ok);
        n = 0;
        if (ok) begin
          p0 = 1'b1;
          ok = 1'b0;
          for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            n++;
            if (outv(it.ch) && !p0) begin ok = 1'b1; break; end
            p0 = outv(it.ch);
          end
        end
        check(ok && n == it.exp, it.tag, n, it.exp);
      end
      K_CONST: begin
        n = it.exp;
        for (int i = 0; i < it.win; i++) begin
          @(negedge clk);
          if (outv(it.ch) != 1'(it.exp)) n = int'(outv(it.ch));
        end
        check(n == it.exp, it.tag, n, it.exp);
      end
      K_OFFS: begin
        p0 = pwm0; p1 = pwm1; ok = 1'b0; r1 = 1'b0; n = 0;
        for (int i = 0; i < LIMIT; i++) begin
          @(negedge clk);
          r1 = pwm1 && !p1;
          if (pwm0 && !p0) begin ok = 1'b1; break; end
          p0 = pwm0; p1 = pwm1;
        end
        if (ok && !r1) begin
          ok = 1'b0;
          p1 = pwm1;
          for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            n++;
            if (pwm1 && !p1) begin ok = 1'b1; break; end
            p1 = pwm1;
          end
        end
        check(ok && n == it.exp, it.tag, n, it.exp);
      end
      default: begin
        ok = 1'b0; n = it.win + 1;
        for (int i = 1; i <= it.win; i++) begin
          @(negedge clk);
          if (outv(it.ch)) begin ok = 1'b1; n = i; break; end
        end
        check(ok, it.tag, n, it.win);
      end
    endcase
  endtask

  // monitor: pops expected items and compares them with what the outputs do
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        mon_busy = 1'b1;
        it = q.pop_front();
        run_item(it);
        mon_busy = 1'b0;
      end
    end
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    bit ok;
    int oldv, newv;
    settle(5);
    rst = 1'b0;
    @(negedge clk);

    // R9: outputs low right after reset and with default on-time of 0
    check(pwm0 == 1'b0, "R9 pwm0 after reset", int'(pwm0), 0);
    check(pwm1 == 1'b0, "R9 pwm1 after reset", int'(pwm1), 0);
    expect_item(K_CONST, 0, 0, 0, 520, "R9 R3 ch0 low with on=0");
    expect_item(K_CONST, 1, 0, 0, 20, "R9 R3 ch1 low with on=0");

    // defaults: period 0xFF -> 512 clocks, zero offset in shared mode
    wr(2, 4);
    wr(3, 4);
    expect_item(K_PER, 0, 512, 0, 0, "R9 default period");
    expect_item(K_HIGH, 0, 8, 8, 0, "R2 high 2*N");
    expect_item(K_OFFS, 0, 0, 0, 0, "R9 zero offset");

    // R5 shared period with rising-edge offset
    wr(2, 10);
    wr(0, 19);
    wr(3, 3);
    wr(1, 5);
    settle(600);
    expect_item(K_PER, 0, 40, 0, 0, "R5 ch0 shared period");
    expect_item(K_PER, 1, 40, 0, 0, "R5 ch1 shared period");
    expect_item(K_OFFS, 0, 12, 0, 0, "R5 offset Q=5");
    expect_item(K_HIGH, 1, 6, 6, 0, "R5 R2 ch1 high from own edge");
    expect_item(K_HIGH, 0, 20, 20, 0, "R2 ch0 high N=10");
    wr(1, 12);
    settle(100);
    expect_item(K_OFFS, 0, 26, 0, 0, "R5 offset Q=12");

    // R8: period write in shared mode must not restart channel 0
    wait_fall(0, ok);
    settle(4);
    wr(0, 19);
    expect_item(K_CONST, 0, 0, 0, 10, "R8 no restart in shared mode");

    // R4 independent channels
    indep_mode = 1'b1;
    wr(2, 3);
    wr(0, 9);
    wr(3, 40);
    wr(1, 30);
    settle(200);
    expect_item(K_PER, 0, 20, 0, 0, "R4 ch0 own period");
    expect_item(K_HIGH, 0, 6, 6, 0, "R4 ch0 own high");
    expect_item(K_CONST, 1, 1, 0, 70, "R3 on above period is 100%");
    wr(3, 0);
    settle(100);
    expect_item(K_CONST, 1, 0, 0, 70, "R3 on=0 is 0%");
    wr(3, 31);
    settle(100);
    expect_item(K_CONST, 1, 1, 0, 70, "R3 on=P+1 is 100%");
    wr(3, 30);
    settle(100);
    expect_item(K_HIGH, 1, 60, 60, 0, "R2 on=P high");
    expect_item(K_PER, 1, 62, 0, 0, "R4 ch1 own period");
    expect_item(K_PER, 0, 20, 0, 0, "R1 ch0 untouched by ch1 writes");

    // R7 restart on period write
    wr(3, 5);
    wr(1, 200);
    settle(450);
    wait_fall(1, ok);
    settle(20);
    wr(1, 200);
    expect_item(K_RISEWIN, 1, 1, 0, 4, "R7 restart raises output");

    // R6 on-time deferral: write during a running pulse
    wr(2, 10);
    wr(0, 49);
    settle(120);
    wait_rise(0, ok);
    wr(2, 30);
    settle(23);
    expect_item(K_CONST, 0, 0, 0, 10, "R6 running pulse keeps old on-time");
    expect_item(K_HIGH, 0, 60, 60, 0, "R6 new on-time next cycle");

    // R6 write swept across the cycle start
    wr(2, 3);
    wr(0, 9);
    settle(60);
    oldv = 3;
    for (int k = 0; k < 20; k++) begin
      newv = (oldv == 3) ? 7 : 3;
      wait_rise(0, ok);
      settle(k);
      wr(2, newv);
      expect_item(K_HIGH, 0, 2 * newv, 2 * oldv, 0, "R6 sweep first pulse whole");
      expect_item(K_HIGH, 0, 2 * newv, 2 * newv, 0, "R6 sweep second pulse new");
      oldv = newv;
    end

    summary();
    $finish;
  end
endmodule